// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Registers

This block holds the controller-wide control state of a four-channel DMA engine: the command byte, the status byte with its request and terminal-count bits, the channel mask, the per-channel mode bytes and the byte-pointer flip-flop. The host writes and reads it through a small indexed port. Only indexes 8 to 15 are decoded here, because indexes 0 to 7 belong to the address and count registers, which live elsewhere.

From the mask and the request bits the block derives a per-channel eligibility vector. A fixed-priority picker turns that vector into a single one-hot grant for the transfer engine. Peripherals raise and drop requests through hold and release inputs. The transfer engine reports terminal count through a pulse input. The address/count block toggles the byte pointer through its own pulse input.

Top module: `dma_ctl_regs`

## Requirements
- R1: A synchronous reset, and a master reset command (a write to index 13), each leave the mask at all ones (4'hF) and the status, command and flip-flop at 0. Only the synchronous reset also clears the four mode bytes to 0.
- R2: A write to index 8 loads `command` from `wdata`, but only when no bit other than bit 2 is set. Any other value, for example 8'h01 or 8'h84, leaves `command` unchanged.
- R3: A write to index 9 selects channel `wdata[1:0]`. It sets that channel's request bit `status[ch+4]` when `wdata[2]` is 1 and clears it when `wdata[2]` is 0. It always clears that channel's terminal-count bit `status[ch]`.
- R4: A write to index 10 sets `mask[wdata[1:0]]` when `wdata[2]` is 1 and clears it when `wdata[2]` is 0. The other mask bits are unchanged.
- R5: A write to index 11 stores the whole of `wdata` as the mode byte of channel `wdata[1:0]`. The byte appears at `mode_flat[8*ch +: 8]`.
- R6: A write to index 12 clears `flip_flop`. Otherwise a `ptr_toggle` pulse inverts it. A clear (index 12 or 13) wins over a toggle in the same cycle.
- R7: In the cycle after a write to index 13, `mask` is 4'hF and `command`, `flip_flop` and `status` are 0, unless a hold or terminal-count pulse in that same cycle sets bits again (see R10, R11).
- R8: A write to index 14 clears all mask bits. A write to index 15 loads `mask` from `wdata[3:0]`.
- R9: While `rd_en` is high, `rdata` shows `status` for index 8 and `{4'b0, mask}` for index 15, and 0 for any other index. `rdata` is 0 while `rd_en` is low. A read of index 8 clears `status[3:0]` at the clock edge.
- R10: At the clock edge, `hold_req[ch]` sets request bit `status[ch+4]` and `release_req[ch]` clears it. Both act after any register write in the same cycle, and release wins over hold.
- R11: A `tc_pulse[ch]` sets `status[ch]` and wins over the clears from R3, R9 and R7 in the same cycle.
- R12: `eligible[ch]` is 1 when `mask[ch]` is 0 and `status[ch+4]` is 1. `grant` is one-hot on the lowest-numbered eligible channel, and is all zero when `command[2]` (controller disable) is 1.
- R13: Writes to indexes 0 to 7 change none of the state in this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| idx | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ptr_toggle | input | 1 | Byte-pointer toggle from the address/count block |
| hold_req | input | 4 | Per-channel request set |
| release_req | input | 4 | Per-channel request clear |
| tc_pulse | input | 4 | Per-channel terminal-count set |
| status | output | 8 | {request[3:0], terminal count[3:0]} |
| mask | output | 4 | Channel mask, 1 = masked |
| command | output | 8 | Command byte |
| flip_flop | output | 1 | Byte-pointer flip-flop |
| mode_flat | output | 32 | Four mode bytes, channel 0 in the low byte |
| eligible | output | 4 | Unmasked channels with a pending request |
| grant | output | 4 | One-hot fixed-priority grant |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. The read-clear property also assumes that no `tc_pulse` arrives in the cycle of a status read, because that pulse would legitimately set a terminal-count bit again. The directed part of the stimulus keeps reads and writes in separate cycles. The random part draws one access kind per cycle and often pulses hold, release, terminal count and the pointer toggle at the same edge as a register write, so the ordering rules of R6, R10 and R11 are exercised against the reference model.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int DW    = 8;
    localparam int IDX_W = 4;
    localparam int ST_W  = 2 * NCH;

    localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;
    localparam int            CMD_DIS_BIT = 2;

    typedef enum logic [IDX_W-1:0] {
        IX_CMD   = 4'd8,
        IX_REQ   = 4'd9,
        IX_SMASK = 4'd10,
        IX_MODE  = 4'd11,
        IX_FFCLR = 4'd12,
        IX_MRST  = 4'd13,
        IX_MCLR  = 4'd14,
        IX_MLOAD = 4'd15
    } ctl_idx_e;

    typedef struct packed {
        logic [NCH-1:0] req;
        logic [NCH-1:0] tc;
    } status_t;

    typedef struct packed {
        logic cmd_wr;
        logic smask_wr;
        logic mode_wr;
        logic ffclr;
        logic mclr;
        logic mload;
        logic mreset;
    } cfg_op_t;

    typedef struct packed {
        logic req_wr;
        logic st_rd;
        logic mreset;
    } st_op_t;

    function automatic logic cmd_ok(input logic [DW-1:0] d);
        return (d & ~CMD_ALLOWED) == '0;
    endfunction

    function automatic logic [NCH-1:0] pick_lowest(input logic [NCH-1:0] v);
        logic [NCH-1:0] g;
        g = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) g = NCH'(1) << i;
        end
        return g;
    endfunction

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    output cfg_op_t          cfg_op,
    output st_op_t           st_op
);

    always_comb begin
        cfg_op = '0;
        st_op  = '0;
        if (wr_en) begin
            case (idx)
                IX_CMD:   cfg_op.cmd_wr   = 1'b1;
                IX_REQ:   st_op.req_wr    = 1'b1;
                IX_SMASK: cfg_op.smask_wr = 1'b1;
                IX_MODE:  cfg_op.mode_wr  = 1'b1;
                IX_FFCLR: cfg_op.ffclr    = 1'b1;
                IX_MRST: begin
                    cfg_op.mreset = 1'b1;
                    st_op.mreset  = 1'b1;
                end
                IX_MCLR:  cfg_op.mclr     = 1'b1;
                IX_MLOAD: cfg_op.mload    = 1'b1;
                default: ;
            endcase
        end
        if (rd_en && idx == IX_CMD) st_op.st_rd = 1'b1;
    end

endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
    import dma_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  st_op_t         op,
    input  logic [CH_W:0]  sel,
    input  logic [NCH-1:0] hold_req,
    input  logic [NCH-1:0] release_req,
    input  logic [NCH-1:0] tc_pulse,
    output status_t        status_q
);

    status_t         nxt;
    logic [CH_W-1:0] ch;

    assign ch = sel[CH_W-1:0];

    always_comb begin
        nxt = status_q;
        if (op.st_rd) nxt.tc = '0;
        if (op.req_wr) begin
            nxt.req[ch] = sel[CH_W];
            nxt.tc[ch]  = 1'b0;
        end
        if (op.mreset) nxt = '0;
        nxt.req = (nxt.req | hold_req) & ~release_req;
        nxt.tc  = nxt.tc | tc_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= nxt;
    end

endmodule

// File: rtl/dma_ctl_cfg.sv
module dma_ctl_cfg
    import dma_ctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  cfg_op_t                 op,
    input  logic [DW-1:0]           wdata,
    input  logic                    ptr_toggle,
    output logic [DW-1:0]           command_q,
    output logic [NCH-1:0]          mask_q,
    output logic                    ff_q,
    output logic [NCH-1:0][DW-1:0]  modes_q
);

    logic [CH_W-1:0] ch;
    assign ch = wdata[CH_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || op.mreset)                    command_q <= '0;
        else if (op.cmd_wr && cmd_ok(wdata))     command_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || op.mreset)  mask_q <= '1;
        else if (op.mclr)      mask_q <= '0;
        else if (op.mload)     mask_q <= wdata[NCH-1:0];
        else if (op.smask_wr)  mask_q[ch] <= wdata[CH_W];
    end

    always_ff @(posedge clk) begin
        if (rst || op.mreset || op.ffclr) ff_q <= 1'b0;
        else if (ptr_toggle)              ff_q <= ~ff_q;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)                                  modes_q[g] <= '0;
            else if (op.mode_wr && ch == CH_W'(g))    modes_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/dma_ctl_arb.sv
module dma_ctl_arb
    import dma_ctl_pkg::*;
(
    input  logic [NCH-1:0] mask_q,
    input  logic [NCH-1:0] req_q,
    input  logic           disable_i,
    output logic [NCH-1:0] eligible,
    output logic [NCH-1:0] grant
);

    assign eligible = req_q & ~mask_q;
    assign grant    = disable_i ? '0 : pick_lowest(eligible);

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    input  logic                ptr_toggle,
    input  logic [NCH-1:0]      hold_req,
    input  logic [NCH-1:0]      release_req,
    input  logic [NCH-1:0]      tc_pulse,
    output logic [ST_W-1:0]     status,
    output logic [NCH-1:0]      mask,
    output logic [DW-1:0]       command,
    output logic                flip_flop,
    output logic [NCH*DW-1:0]   mode_flat,
    output logic [NCH-1:0]      eligible,
    output logic [NCH-1:0]      grant
);

    cfg_op_t                cfg_op;
    st_op_t                 st_op;
    status_t                status_q;
    logic [NCH-1:0][DW-1:0] modes_q;

    dma_ctl_decode u_dec (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .idx    (idx),
        .cfg_op (cfg_op),
        .st_op  (st_op)
    );

    dma_ctl_status u_st (
        .clk         (clk),
        .rst         (rst),
        .op          (st_op),
        .sel         (wdata[CH_W:0]),
        .hold_req    (hold_req),
        .release_req (release_req),
        .tc_pulse    (tc_pulse),
        .status_q    (status_q)
    );

    dma_ctl_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .op         (cfg_op),
        .wdata      (wdata),
        .ptr_toggle (ptr_toggle),
        .command_q  (command),
        .mask_q     (mask),
        .ff_q       (flip_flop),
        .modes_q    (modes_q)
    );

    dma_ctl_arb u_arb (
        .mask_q    (mask),
        .req_q     (status_q.req),
        .disable_i (command[CMD_DIS_BIT]),
        .eligible  (eligible),
        .grant     (grant)
    );

    assign status    = status_q;
    assign mode_flat = modes_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (idx)
                IX_CMD:   rdata = DW'(status_q);
                IX_MLOAD: rdata = DW'(mask);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
    import dma_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [IDX_W-1:0] idx,
    input logic [DW-1:0]    wdata,
    input logic [NCH-1:0]   release_req,
    input logic [NCH-1:0]   tc_pulse,
    input logic [ST_W-1:0]  status,
    input logic [NCH-1:0]   mask,
    input logic [DW-1:0]    command,
    input logic [NCH-1:0]   eligible,
    input logic [NCH-1:0]   grant
);

    assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_in_elig_R12: assert property (@(posedge clk) disable iff (rst)
        (grant & ~eligible) == '0);

    assert_grant_off_R12: assert property (@(posedge clk) disable iff (rst)
        command[CMD_DIS_BIT] |-> grant == '0);

    assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 4'd8 && (wdata & ~CMD_ALLOWED) != '0) |=> $stable(command));

    assert_master_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 4'd13) |=> (mask == '1 && command == '0));

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && idx == 4'd8 && tc_pulse == '0) |=> status[NCH-1:0] == '0);

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (release_req != '0) |=> (status[ST_W-1:NCH] & $past(release_req)) == '0);

    assert_low_index_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idx[IDX_W-1]) |=> ($stable(mask) && $stable(command)));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .idx         (idx),
    .wdata       (wdata),
    .release_req (release_req),
    .tc_pulse    (tc_pulse),
    .status      (status),
    .mask        (mask),
    .command     (command),
    .eligible    (eligible),
    .grant       (grant)
);

// File: tb/dma_ctl_regs_test.sv
`timescale 1ns/1ps
module dma_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, ptr_toggle = 1'b0;
    logic [3:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  hold_req = '0, release_req = '0, tc_pulse = '0;
    logic [7:0]  rdata, status, command;
    logic [3:0]  mask, eligible, grant;
    logic        flip_flop;
    logic [31:0] mode_flat;

    always #4 clk = ~clk;

    dma_ctl_regs uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
        .wdata(wdata), .rdata(rdata), .ptr_toggle(ptr_toggle),
        .hold_req(hold_req), .release_req(release_req), .tc_pulse(tc_pulse),
        .status(status), .mask(mask), .command(command), .flip_flop(flip_flop),
        .mode_flat(mode_flat), .eligible(eligible), .grant(grant)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mask, m_status, m_cmd, m_ff;
    int m_mode[4];
    bit m_valid = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_grant();
        int e;
        e = m_status[7:4] & ~m_mask & 4'hF;
        if (m_cmd & 4) return 0;
        for (int i = 0; i < 4; i++) if (e & (1 << i)) return 1 << i;
        return 0;
    endfunction

    task automatic compare(input string tag);
        int er, mf;
        er = 0;
        if (rd_en) begin
            if (idx == 8) er = m_status;
            else if (idx == 15) er = m_mask;
        end
        mf = 0;
        for (int i = 0; i < 4; i++) mf |= (m_mode[i] & 8'hFF) << (8 * i);
        chk(tag, "rdata", int'(rdata), er);
        chk(tag, "status", int'(status), m_status);
        chk(tag, "mask", int'(mask), m_mask);
        chk(tag, "command", int'(command), m_cmd);
        chk(tag, "flip_flop", int'(flip_flop), m_ff);
        chk(tag, "mode_flat", int'(mode_flat), mf);
        chk(tag, "eligible", int'(eligible), m_status[7:4] & ~m_mask & 4'hF);
        chk(tag, "grant", int'(grant), exp_grant());
    endtask

    task automatic model_step();
        int d, ch;
        d = int'(wdata);
        ch = d & 3;
        if (rst) begin
            m_mask = 15; m_status = 0; m_cmd = 0; m_ff = 0;
            for (int i = 0; i < 4; i++) m_mode[i] = 0;
            return;
        end
        if (rd_en && idx == 8) m_status &= 8'hF0;
        if (ptr_toggle) m_ff ^= 1;
        if (wr_en) begin
            case (int'(idx))
                8:  if ((d & 8'hFB) == 0) m_cmd = d;
                9:  begin
                        if (d & 4) m_status |= 1 << (ch + 4);
                        else m_status &= ~(1 << (ch + 4));
                        m_status &= ~(1 << ch);
                    end
                10: if (d & 4) m_mask |= 1 << ch; else m_mask &= ~(1 << ch) & 15;
                11: m_mode[ch] = d;
                12: m_ff = 0;
                13: begin m_ff = 0; m_mask = 15; m_status = 0; m_cmd = 0; end
                14: m_mask = 0;
                15: m_mask = d & 15;
                default: ;
            endcase
        end
        m_status |= int'(hold_req) << 4;
        m_status &= ~(int'(release_req) << 4) & 8'hFF;
        m_status |= int'(tc_pulse);
    endtask

    task automatic tick(input string tag, input bit w, input bit r, input int ix,
                        input int d, input bit pt, input int h, input int rl, input int t);
        wr_en = w; rd_en = r; idx = 4'(ix); wdata = 8'(d); ptr_toggle = pt;
        hold_req = 4'(h); release_req = 4'(rl); tc_pulse = 4'(t);
        #1;
        if (m_valid) compare(tag);
        @(posedge clk);
        model_step();
        m_valid = 1;
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input int ix, input int d);
        tick(tag, 1, 0, ix, d, 0, 0, 0, 0);
    endtask

    task automatic rd(input string tag, input int ix);
        tick(tag, 0, 1, ix, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(input string tag);
        tick(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick("R1", 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        idle("R1");                                   // R1 reset state
        // R2 command acceptance and rejection
        wr("R2", 8, 8'h04); idle("R2");
        wr("R2", 8, 8'h01); idle("R2");
        wr("R2", 8, 8'h00); idle("R2");
        wr("R2", 8, 8'h84); idle("R2");
        // R8 mask clear and load
        wr("R8", 14, 0); idle("R8");
        wr("R8", 15, 8'hFA); idle("R8");
        wr("R8", 14, 0); idle("R8");
        // R3 request writes and terminal-count clearing
        tick("R11", 0, 0, 0, 0, 0, 0, 0, 4'hF); idle("R11");
        wr("R3", 9, 8'h05); idle("R3");
        wr("R3", 9, 8'h03); idle("R3");
        wr("R3", 9, 8'h01); idle("R3");
        // R4 single-channel mask
        wr("R4", 10, 8'h06); idle("R4");
        wr("R4", 10, 8'h02); idle("R4");
        // R5 mode bytes
        wr("R5", 11, 8'h5B); wr("R5", 11, 8'hA4); wr("R5", 11, 8'h3D); idle("R5");
        // R6 flip-flop
        tick("R6", 0, 0, 0, 0, 1, 0, 0, 0); idle("R6");
        tick("R6", 1, 0, 12, 0, 1, 0, 0, 0); idle("R6");
        tick("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        tick("R6", 1, 0, 12, 0, 0, 0, 0, 0); idle("R6");
        // R9 reads
        tick("R9", 0, 0, 0, 0, 0, 4'h6, 0, 4'h9);
        rd("R9", 8); idle("R9");
        rd("R9", 15); rd("R9", 3); rd("R9", 12); idle("R9");
        // R10 hold and release
        tick("R10", 0, 0, 0, 0, 0, 4'hF, 0, 0); idle("R10");
        tick("R10", 0, 0, 0, 0, 0, 4'h3, 4'h1, 0); idle("R10");
        tick("R10", 1, 0, 9, 8'h04, 0, 0, 4'h1, 0); idle("R10");
        // R11 terminal count wins over read clear and request write
        tick("R11", 0, 1, 8, 0, 0, 0, 0, 4'h2); idle("R11");
        tick("R11", 1, 0, 9, 8'h06, 0, 0, 0, 4'h4); idle("R11");
        // R12 priority and disable
        wr("R12", 14, 0); tick("R12", 0, 0, 0, 0, 0, 4'hE, 0, 0); idle("R12");
        wr("R12", 10, 8'h05); idle("R12");
        wr("R12", 8, 8'h04); idle("R12");
        wr("R12", 8, 8'h00); idle("R12");
        // R13 low indexes are inert
        wr("R13", 2, 8'hFF); wr("R13", 7, 8'h00); wr("R13", 0, 8'h04); idle("R13");
        // R7 master reset, alone and with a hold in the same cycle
        tick("R6", 0, 0, 0, 0, 1, 0, 0, 0);
        wr("R7", 13, 0); idle("R7");
        tick("R7", 1, 0, 13, 0, 0, 4'h8, 0, 4'h1); idle("R7");
        // random mix, every output compared each cycle
        for (int n = 0; n < 3000; n++) begin
            int kind;
            kind = $urandom_range(0, 2);
            tick("R12", kind == 1, kind == 2, $urandom_range(0, 15), $urandom_range(0, 255),
                 ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 2) == 0) ? $urandom_range(0, 15) : 0,
                 ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0,
                 ($urandom_range(0, 4) == 0) ? $urandom_range(0, 15) : 0);
        end
        idle("R12");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule